// File: doc/BRIEF.md
# Two-Wire Serial Slave with Pointer-Addressed Register Bank

This block lets a two-wire serial master reach a bank of 8-bit control registers. SCL and SDA are sampled by the system clock and pass through a two-flop synchronizer. The block answers on SDA only through an open-drain output enable. While `sda_oe` is high the pad pulls the line low. While it is low the line is released.

The device address has 7 bits. Its upper six bits are fixed, and the `addr_sel` pin supplies the last bit. A write transaction sends its first data byte into an internal byte pointer. Every later byte lands in the register that the pointer selects, and the pointer then steps forward. A read transaction returns the register at the pointer and steps the pointer after each byte.

The pointer survives a repeated start. A master can therefore set the pointer with a short write and then switch to reading without a stop. The rest of the chip sees every register through a combinational peek port.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `{6'b100010, addr_sel}`. That gives 0x88/0x89 with `addr_sel`=0 and 0x8A/0x8B with `addr_sel`=1. On a mismatch SDA stays released for the whole transaction and no register or pointer changes.
- R2: Address and data bytes are shifted MSB first, in both directions.
- R3: When bit 0 of the address byte is 0 (write), the first following byte loads the pointer. Each later byte is stored at the register the pointer selects, and the pointer then increments. Every byte of a matched write is acknowledged.
- R4: When bit 0 of the address byte is 1 (read), the slave drives the register at the pointer MSB first and increments the pointer once per byte. It continues with the next register for as long as the master acknowledges.
- R5: A master NACK after a read byte makes the slave release SDA and wait for a start or stop. The pointer keeps its incremented value.
- R6: The pointer wraps from 0xFF to 0x00.
- R7: The pointer is kept across a repeated start, so a pointer-setting write followed by a repeated-start read returns data from that pointer.
- R8: A start or stop that arrives before the eighth bit of a byte abandons that byte. No register is written and the pointer does not move.
- R9: `sda_oe` changes only while SCL is low. It is low whenever the slave is idle.
- R10: After reset all 256 registers read zero, the pointer is zero and `sda_oe` is low.
- R11: `peek_val` always equals the register selected by `peek_idx`. A register written by the bus is visible on the port once its byte has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the pad |
| sda_in | input | 1 | Serial data from the pad (wired-AND bus level) |
| addr_sel | input | 1 | Chooses the low bit of the device address |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| peek_idx | input | 8 | Register index for the parallel read port |
| peek_val | output | 8 | Contents of the indexed register |

## Verification
A bus write and the parallel peek port can touch the same register in the same cycle. The commit lands on the SCL fall that closes the eighth bit, and at that moment the peek port may be watching the very entry being written. The bench aims `peek_idx` at the pointer's target while data bytes stream in. It then checks that the port shows the new byte right after the acknowledge, and the old byte for a transfer cut short by a stop or a repeated start. Pointer wrap at 0xFF and a repeated start that follows a pointer load are also forced in directed sequences, and each is judged against a bench-side register model.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int PTR_W = 8,
  parameter logic [6:0] BASE_ADDR = 7'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             addr_sel,
  output logic             sda_oe,
  input  logic [PTR_W-1:0] peek_idx,
  output logic [7:0]       peek_val
);
  localparam int DEPTH = 1 << PTR_W;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;
  st_t st;
  kind_t kind;
  logic rw, mack;
  logic [PTR_W-1:0] ptr;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [7:0] mem [DEPTH];
  logic byte_done, addr_hit, wr_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign byte_done = (st == S_RX) && scl_fall && (cnt == 4'd8);
  assign addr_hit  = sh[7:1] == {BASE_ADDR[6:1], addr_sel};
  assign wr_en     = byte_done && (kind == K_DATA);
  assign peek_val  = mem[peek_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; rw <= 1'b0; mack <= 1'b0;
      ptr <= '0; sh <= '0; cnt <= '0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (kind == K_ADDR && !addr_hit) st <= S_IDLE;
            else begin
              st <= S_ACK;
              sda_oe <= 1'b1;
              if (kind == K_ADDR) begin
                rw <= sh[0]; kind <= K_PTR;
              end else if (kind == K_PTR) begin
                ptr <= sh[PTR_W-1:0]; kind <= K_DATA;
              end else ptr <= ptr + 1'b1;
            end
          end
        S_ACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= S_TX; sh <= mem[ptr]; ptr <= ptr + 1'b1; sda_oe <= ~mem[ptr][7];
            end else begin
              st <= S_RX; sda_oe <= 1'b0;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= S_MACK; sda_oe <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
        S_MACK:
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              st <= S_TX; sh <= mem[ptr]; ptr <= ptr + 1'b1; sda_oe <= ~mem[ptr][7];
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) mem[ptr] <= sh;

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_done && kind == K_ADDR) |-> sda_oe == $past(addr_hit)); // R1
  AST_WRITE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rw); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && !$past(byte_done && kind == K_PTR)) |-> (ptr - $past(ptr)) == PTR_W'(1)); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == S_IDLE && !sda_oe); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s) || $past(start_det || stop_det)); // R9
endmodule

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
  localparam int Q = 5;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, sel = 1'b0;
  logic oe, sda_bus;
  logic [7:0] idx = '0, val;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = '0;
  int nchk = 0, nerr = 0;
  logic oe_prev = 1'b0;

  assign sda_bus = m_sda & ~oe;
  always #4 clk = ~clk;

  i2c_regfile_slave u_i2c_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .addr_sel(sel),
    .sda_oe(oe), .peek_idx(idx), .peek_val(val));

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_hit(logic [7:0] ab);
    return ab[7:1] == {6'b100010, sel};
  endfunction

  task automatic bus_start();
    m_sda = 1; tick(Q); scl = 1; tick(Q); m_sda = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bus_stop();
    m_sda = 0; tick(Q); scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask
  task automatic put_bit(bit b);
    m_sda = b; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q);
  endtask
  task automatic get_bit(output bit b);
    m_sda = 1; tick(Q); scl = 1; tick(Q); b = sda_bus; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic send_byte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic peek(logic [7:0] a, string req);
    idx = a; tick(1);
    check(val == ref_mem[a], req, val, ref_mem[a]);
  endtask

  // write transaction: address byte, pointer byte, n data bytes
  task automatic do_write(logic [7:0] ab, logic [7:0] p, int n, bit fixed, logic [7:0] fv, bit end_stop);
    bit ack, hit;
    logic [7:0] d;
    hit = exp_hit(ab);
    bus_start();
    send_byte(ab, ack); check(ack == hit, "R1", ack, hit);
    send_byte(p, ack); check(ack == hit, "R3", ack, hit);
    if (hit) ref_ptr = p;
    for (int k = 0; k < n; k++) begin
      d = fixed ? fv : 8'($urandom);
      if (hit) idx = ref_ptr;
      send_byte(d, ack); check(ack == hit, "R3", ack, hit);
      if (hit) begin
        ref_mem[ref_ptr] = d;
        check(val == d, "R11", val, d);
        ref_ptr++;
      end
    end
    if (end_stop) bus_stop();
  endtask

  task automatic do_read(logic [7:0] ab, int n);
    bit ack, hit;
    logic [7:0] d;
    hit = exp_hit(ab);
    bus_start();
    send_byte(ab, ack); check(ack == hit, "R1", ack, hit);
    if (hit)
      for (int k = 0; k < n; k++) begin
        recv_byte(k != n - 1, d);
        check(d == ref_mem[ref_ptr], "R4", d, ref_mem[ref_ptr]);
        ref_ptr++;
      end
    bus_stop();
    check(oe == 1'b0, "R5", oe, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && oe !== oe_prev) check(scl == 1'b0, "R9", scl, 0);
    oe_prev <= oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit ack;
    void'($urandom(32'd829));
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    tick(4); rst_n = 1; tick(4);
    check(oe == 1'b0, "R10", oe, 0);
    for (int i = 0; i < 256; i++) begin
      idx = 8'(i); tick(1);
      check(val == 8'h00, "R10", val, 0);
    end
    sel = 0; do_read(8'h89, 2);                          // R10 pointer starts at zero
    sel = 0; do_write(8'h88, 8'h10, 2, 1'b0, 8'h00, 1'b1);
    sel = 1; do_write(8'h88, 8'h30, 2, 1'b0, 8'h00, 1'b1); // R1 mismatch, no effect
    peek(8'h30, "R1"); peek(8'h31, "R1");
    sel = 1; do_write(8'h8A, 8'h40, 1, 1'b1, 8'h01, 1'b1);  // R2
    do_write(8'h8A, 8'h41, 1, 1'b1, 8'h80, 1'b1);
    peek(8'h40, "R2"); peek(8'h41, "R2");
    do_write(8'h8A, 8'h42, 1, 1'b1, 8'h96, 1'b0);
    do_write(8'h8A, 8'h42, 0, 1'b0, 8'h00, 1'b0);           // R7 pointer set, repeated start
    do_read(8'h8B, 1);
    do_read(8'h8B, 1);                                       // R5 pointer kept after NACK
    do_write(8'h8A, 8'hFE, 4, 1'b0, 8'h00, 1'b1);            // R6 wrap
    peek(8'hFF, "R6"); peek(8'h00, "R6"); peek(8'h01, "R6");
    do_write(8'h8A, 8'hFF, 0, 1'b0, 8'h00, 1'b1);
    do_read(8'h8B, 3);                                       // R6 read wrap
    // R8: abort mid-byte by stop, then by repeated start
    do_write(8'h8A, 8'h20, 1, 1'b1, 8'hAA, 1'b0);
    for (int b = 0; b < 5; b++) put_bit(b[0]);
    bus_stop();
    peek(8'h21, "R8");
    do_read(8'h8B, 1);
    do_write(8'h8A, 8'h50, 0, 1'b0, 8'h00, 1'b0);
    for (int b = 0; b < 3; b++) put_bit(1'b0);
    do_read(8'h8B, 1);
    peek(8'h50, "R8");
    // constrained random transactions
    for (int t = 0; t < 24; t++) begin
      logic [7:0] ab;
      sel = 1'($urandom);
      ab = {6'b100010, sel, 1'b0};
      if ($urandom_range(0, 4) == 0) ab[7:1] = ab[7:1] ^ 7'(1 << $urandom_range(0, 6));
      do_write(ab, 8'($urandom), $urandom_range(1, 4), 1'b0, 8'h00, 1'($urandom));
      peek(8'($urandom), "R11");
      ab = {6'b100010, sel, 1'b1};
      if ($urandom_range(0, 4) == 0) ab[1] = ~ab[1];
      do_read(ab, $urandom_range(1, 4));
    end
    tick(10);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule